// File: doc/BRIEF.md
# Nonvolatile DIMM backup controller

This controller sits on a memory module whose DRAM is backed by flash and a supercapacitor. It decides at every moment who owns the DRAM. While the module runs normally, the host uses the DRAM like any other registered DIMM. When a backup is due, the controller takes the DRAM away from the host, moves its power onto the supercapacitor and starts a DRAM-to-flash copy. After the copy it switches the capacitor off and sits in a zero-power state. On the next power-up it starts a flash-to-DRAM restore before the host sees the DRAM again. The copy and restore engines themselves are outside this block. Each one is reached through a one-cycle start pulse and a done strobe that carries an error flag.

A backup can only start once the module is armed. The host arms it with a command, and the command takes effect only while the health input is good and the capacitor charge level is at or above a threshold. The host requests a save by pulling the shared, active-low save line low. The module pulls the same line low itself to report that the save has completed. A one-cycle event output tells the host that the status has changed. Three sticky status bits and an image-valid flag report the outcome of save and restore attempts.

Top module: `nvbk_ctrl`

## Requirements
- R1: After reset, all of the following hold. The DRAM is isolated (iso_o=1) and not owned by the host. The capacitor is not selected. No start pulse is issued. The module is not armed. Every status bit and img_valid_o are 0. The save line is released (save_n_oe_o=0).
- R2: Suppose pwr_good_i rises while no valid flash image exists. The DRAM is then handed to the host (host_owns_o=1, iso_o=0) with no restore pulse. st_no_data_o becomes 1, and event_o pulses.
- R3: arm_cmd_i sets armed_o only when three things hold: the host owns the DRAM, health_ok_i=1, and cap_level_i>=CAP_MIN. Otherwise the command is ignored. armed_o clears as soon as health_ok_i drops or the charge level falls below CAP_MIN.
- R4: A falling edge on the save line while the module is not armed is ignored. The host keeps the DRAM, iso_o stays 0 and no copy starts. The sticky bit st_not_armed_o is set and event_o pulses.
- R5: A falling edge on the save line while the module is armed raises iso_o and cap_sel_o. Both are already high in the clock before a single-cycle copy_start_o pulse.
- R6: A copy_done_i without error does the following. It sets img_valid_o and releases cap_sel_o. It enters the zero-power state (zero_pwr_o=1), in which the module pulls the save line low (save_n_oe_o=1).
- R7: If pwr_good_i falls while the module is armed and the host owns the DRAM, a save starts just as it does for a save request.
- R8: Suppose power returns while a valid image exists. Exactly one rest_start_o pulse is issued. The DRAM stays isolated and not host-owned until rest_done_i. After that the host owns it and st_no_data_o is 0.
- R9: A copy or restore that completes with its error flag set does three things. It sets the sticky st_error_o, pulses event_o and clears img_valid_o. The next power-up therefore hands the DRAM over with st_no_data_o=1 and no restore.
- R10: The zero-power state is left only when pwr_good_i falls. The DRAM is not handed to the host again until pwr_good_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_good_i | input | 1 | Host power good, synchronous |
| save_n_i | input | 1 | Sensed level of the shared active-low save line |
| save_n_oe_o | output | 1 | Pull the save line low (save complete) |
| cap_level_i | input | CAP_W | Supercapacitor charge level |
| health_ok_i | input | 1 | Module health checks cleared |
| arm_cmd_i | input | 1 | Host arm command, one cycle |
| iso_o | output | 1 | DRAM isolated from the host |
| cap_sel_o | output | 1 | DRAM powered from the supercapacitor |
| copy_start_o | output | 1 | DRAM-to-flash copy start pulse |
| copy_done_i | input | 1 | Copy finished strobe |
| copy_err_i | input | 1 | Copy error, valid with copy_done_i |
| rest_start_o | output | 1 | Flash-to-DRAM restore start pulse |
| rest_done_i | input | 1 | Restore finished strobe |
| rest_err_i | input | 1 | Restore error, valid with rest_done_i |
| host_owns_o | output | 1 | Host owns the DRAM |
| zero_pwr_o | output | 1 | Zero-power state after a save |
| armed_o | output | 1 | Backup armed |
| event_o | output | 1 | Status change notification pulse |
| img_valid_o | output | 1 | Flash holds a valid image |
| st_not_armed_o | output | 1 | Sticky: save requested while not armed |
| st_error_o | output | 1 | Sticky: copy or restore error |
| st_no_data_o | output | 1 | Last power-up handed over without restore |

## Verification
A sequencer stuck in the wrong mode shows up at once at host_owns_o and iso_o, one clock after the input that should have moved it. A lost image-valid flag appears only at the next power-up: a restore that should start does not, or one that should not start does. An arming gate that is wrong appears first when a save request is refused or accepted, two to three clocks after the save line falls. Ordering faults between isolation and copy start are visible as a single-cycle slip, so the bench compares the outputs every cycle around the copy start.

// File: rtl/nvbk_pkg.sv
package nvbk_pkg;
    typedef enum logic [2:0] {
        S_INIT, S_REST, S_HOST, S_ISO, S_COPY, S_OFF
    } mode_e;

    typedef struct packed {
        mode_e state;
        logic  iso;
        logic  cap;
        logic  copy_start;
        logic  rest_start;
        logic  zero;
        logic  oe;
        logic  event_p;
        logic  img_valid;
        logic  not_armed;
        logic  err;
        logic  no_data;
    } seq_t;
endpackage

// File: rtl/nvbk_sync_fall.sv
module nvbk_sync_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d[0] = line_i;
        for (int i = 1; i < STAGES; i++) sync_d[i] = sync_q[i-1];
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/nvbk_arm.sv
module nvbk_arm #(
    parameter int CAP_W   = 8,
    parameter int CAP_MIN = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             allow_i,
    input  logic             arm_cmd_i,
    input  logic             health_ok_i,
    input  logic [CAP_W-1:0] cap_level_i,
    output logic             armed_o,
    output logic             change_o
);
    localparam logic [CAP_W-1:0] CapThr = CAP_W'(CAP_MIN);

    logic gate_ok;
    logic armed_d, armed_q;

    always_comb begin
        gate_ok = health_ok_i && (cap_level_i >= CapThr);
        armed_d = allow_i && gate_ok && (armed_q || arm_cmd_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    assign armed_o  = armed_q;
    assign change_o = armed_d != armed_q;

    assert_arm_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> $past(health_ok_i) && ($past(cap_level_i) >= CapThr));
endmodule

// File: rtl/nvbk_ctrl.sv
module nvbk_ctrl
    import nvbk_pkg::*;
#(
    parameter int CAP_W       = 8,
    parameter int CAP_MIN     = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good_i,
    input  logic             save_n_i,
    output logic             save_n_oe_o,
    input  logic [CAP_W-1:0] cap_level_i,
    input  logic             health_ok_i,
    input  logic             arm_cmd_i,
    output logic             iso_o,
    output logic             cap_sel_o,
    output logic             copy_start_o,
    input  logic             copy_done_i,
    input  logic             copy_err_i,
    output logic             rest_start_o,
    input  logic             rest_done_i,
    input  logic             rest_err_i,
    output logic             host_owns_o,
    output logic             zero_pwr_o,
    output logic             armed_o,
    output logic             event_o,
    output logic             img_valid_o,
    output logic             st_not_armed_o,
    output logic             st_error_o,
    output logic             st_no_data_o
);
    seq_t st_d, st_q;
    logic save_fall;
    logic armed, arm_change;

    nvbk_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (save_n_i),
        .fall_o (save_fall)
    );

    nvbk_arm #(.CAP_W(CAP_W), .CAP_MIN(CAP_MIN)) u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .allow_i     (st_q.state == S_HOST),
        .arm_cmd_i   (arm_cmd_i),
        .health_ok_i (health_ok_i),
        .cap_level_i (cap_level_i),
        .armed_o     (armed),
        .change_o    (arm_change)
    );

    always_comb begin
        st_d            = st_q;
        st_d.copy_start = 1'b0;
        st_d.rest_start = 1'b0;
        st_d.event_p    = arm_change;
        unique case (st_q.state)
            S_INIT: begin
                st_d.iso = 1'b1;
                if (pwr_good_i) begin
                    if (st_q.img_valid) begin
                        st_d.rest_start = 1'b1;
                        st_d.state      = S_REST;
                    end else begin
                        st_d.state   = S_HOST;
                        st_d.iso     = 1'b0;
                        st_d.no_data = 1'b1;
                        st_d.event_p = 1'b1;
                    end
                end
            end
            S_REST: begin
                if (rest_done_i) begin
                    st_d.state = S_HOST;
                    st_d.iso   = 1'b0;
                    if (rest_err_i) begin
                        st_d.err       = 1'b1;
                        st_d.img_valid = 1'b0;
                        st_d.no_data   = 1'b1;
                        st_d.event_p   = 1'b1;
                    end else begin
                        st_d.no_data = 1'b0;
                    end
                end
            end
            S_HOST: begin
                if (armed && (save_fall || !pwr_good_i)) begin
                    st_d.state = S_ISO;
                    st_d.iso   = 1'b1;
                    st_d.cap   = 1'b1;
                end else if (!pwr_good_i) begin
                    st_d.state = S_INIT;
                    st_d.iso   = 1'b1;
                end else if (save_fall) begin
                    st_d.not_armed = 1'b1;
                    st_d.event_p   = 1'b1;
                end
            end
            S_ISO: begin
                st_d.state      = S_COPY;
                st_d.copy_start = 1'b1;
            end
            S_COPY: begin
                if (copy_done_i) begin
                    st_d.state = S_OFF;
                    st_d.cap   = 1'b0;
                    st_d.zero  = 1'b1;
                    st_d.oe    = 1'b1;
                    if (copy_err_i) begin
                        st_d.err       = 1'b1;
                        st_d.img_valid = 1'b0;
                        st_d.event_p   = 1'b1;
                    end else begin
                        st_d.img_valid = 1'b1;
                    end
                end
            end
            S_OFF: begin
                if (!pwr_good_i) begin
                    st_d.state = S_INIT;
                    st_d.zero  = 1'b0;
                    st_d.oe    = 1'b0;
                end
            end
            default: st_d.state = S_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= S_INIT;
            st_q.iso   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign save_n_oe_o    = st_q.oe;
    assign iso_o          = st_q.iso;
    assign cap_sel_o      = st_q.cap;
    assign copy_start_o   = st_q.copy_start;
    assign rest_start_o   = st_q.rest_start;
    assign host_owns_o    = st_q.state == S_HOST;
    assign zero_pwr_o     = st_q.zero;
    assign armed_o        = armed;
    assign event_o        = st_q.event_p;
    assign img_valid_o    = st_q.img_valid;
    assign st_not_armed_o = st_q.not_armed;
    assign st_error_o     = st_q.err;
    assign st_no_data_o   = st_q.no_data;

    assert_copy_after_iso_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.copy_start |-> $past(st_q.iso) && $past(st_q.cap));

    assert_copy_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.copy_start |=> !st_q.copy_start);

    assert_host_not_iso_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == S_HOST) |-> !st_q.iso && !st_q.cap);

    assert_oe_no_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.oe |-> !st_q.cap && st_q.iso);

    assert_rest_needs_image_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rest_start |-> $past(st_q.img_valid));

    assert_rest_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == S_REST) |-> st_q.iso);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.err) |-> st_q.err);

    assert_off_until_pwr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.state) == S_OFF) && (st_q.state != S_OFF) |-> !$past(pwr_good_i));
endmodule

// File: tb/sim_nvbk_ctrl.sv
`timescale 1ns/100ps
module sim_nvbk_ctrl;
    localparam int CAP_W   = 8;
    localparam int CAP_MIN = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic host_save_n = 1'b1;
    logic save_n_line;
    logic save_n_oe;
    logic [CAP_W-1:0] cap_level = '0;
    logic health_ok = 1'b0;
    logic arm_cmd = 1'b0;
    logic iso, cap_sel, copy_start, rest_start;
    logic copy_done = 1'b0, copy_err = 1'b0, rest_done = 1'b0, rest_err = 1'b0;
    logic host_owns, zero_pwr, armed, event_p, img_valid;
    logic st_not_armed, st_error, st_no_data;

    int checks = 0, errors = 0;
    int n_copy = 0, n_rest = 0, n_event = 0, order_bad = 0, cycles = 0;
    logic prev_iso = 1'b0, prev_cap = 1'b0;
    logic mv_err = 1'b0;

    assign save_n_line = host_save_n & ~save_n_oe;

    always #2.5 clk = ~clk;

    nvbk_ctrl #(.CAP_W(CAP_W), .CAP_MIN(CAP_MIN)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good), .save_n_i(save_n_line),
        .save_n_oe_o(save_n_oe), .cap_level_i(cap_level), .health_ok_i(health_ok),
        .arm_cmd_i(arm_cmd), .iso_o(iso), .cap_sel_o(cap_sel),
        .copy_start_o(copy_start), .copy_done_i(copy_done), .copy_err_i(copy_err),
        .rest_start_o(rest_start), .rest_done_i(rest_done), .rest_err_i(rest_err),
        .host_owns_o(host_owns), .zero_pwr_o(zero_pwr), .armed_o(armed),
        .event_o(event_p), .img_valid_o(img_valid), .st_not_armed_o(st_not_armed),
        .st_error_o(st_error), .st_no_data_o(st_no_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pulse counts and isolation ordering around copy start
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (copy_start) begin
                n_copy++;
                if (!(prev_iso && prev_cap)) order_bad++;
            end
            if (rest_start) n_rest++;
            if (event_p) n_event++;
            prev_iso = iso;
            prev_cap = cap_sel;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    // copy engine model
    initial begin
        forever begin
            @(negedge clk);
            if (copy_start) begin
                tick(4);
                copy_err  = mv_err;
                copy_done = 1'b1;
                tick(1);
                copy_done = 1'b0;
                copy_err  = 1'b0;
            end
        end
    end

    task automatic wait_host(input int lim);
        for (int i = 0; i < lim && !host_owns; i++) tick(1);
    endtask

    task automatic wait_zero(input int lim);
        for (int i = 0; i < lim && !zero_pwr; i++) tick(1);
    endtask

    task automatic do_arm;
        cap_level = CAP_W'(CAP_MIN);
        health_ok = 1'b1;
        arm_cmd = 1'b1;
        tick(1);
        arm_cmd = 1'b0;
        tick(1);
    endtask

    task automatic t_reset;
        tick(1);
        chk("R1 iso", iso, 1);
        chk("R1 host_owns", host_owns, 0);
        chk("R1 cap_sel", cap_sel, 0);
        chk("R1 armed", armed, 0);
        chk("R1 status", {st_not_armed, st_error, st_no_data, img_valid}, 0);
        chk("R1 save_n_oe", save_n_oe, 0);
        chk("R1 starts", n_copy + n_rest, 0);
    endtask

    task automatic t_nodata_powerup;
        int ev0 = n_event;
        pwr_good = 1'b1;
        wait_host(20);
        tick(1);
        chk("R2 host_owns", host_owns, 1);
        chk("R2 iso", iso, 0);
        chk("R2 no_data", st_no_data, 1);
        chk("R2 no restore", n_rest, 0);
        chk("R2 event", n_event - ev0, 1);
    endtask

    task automatic t_unarmed_save;
        int ev0 = n_event;
        host_save_n = 1'b0;
        tick(8);
        chk("R4 host keeps", host_owns, 1);
        chk("R4 iso", iso, 0);
        chk("R4 no copy", n_copy, 0);
        chk("R4 sticky", st_not_armed, 1);
        chk("R4 event", n_event - ev0, 1);
        host_save_n = 1'b1;
        tick(4);
    endtask

    task automatic t_arm_gates;
        cap_level = CAP_W'(CAP_MIN - 1);
        health_ok = 1'b1;
        arm_cmd = 1'b1; tick(1); arm_cmd = 1'b0; tick(1);
        chk("R3 low charge", armed, 0);
        cap_level = CAP_W'(CAP_MIN);
        health_ok = 1'b0;
        arm_cmd = 1'b1; tick(1); arm_cmd = 1'b0; tick(1);
        chk("R3 bad health", armed, 0);
        do_arm;
        chk("R3 threshold arm", armed, 1);
        health_ok = 1'b0; tick(2);
        chk("R3 health drop", armed, 0);
        health_ok = 1'b1; tick(2);
        chk("R3 no self rearm", armed, 0);
        do_arm;
        cap_level = CAP_W'(CAP_MIN - 1); tick(2);
        chk("R3 charge drop", armed, 0);
    endtask

    task automatic t_save_ok;
        do_arm;
        mv_err = 1'b0;
        host_save_n = 1'b0;
        for (int i = 0; i < 20 && n_copy == 0; i++) tick(1);
        chk("R5 iso", iso, 1);
        chk("R5 cap_sel", cap_sel, 1);
        chk("R5 host released", host_owns, 0);
        chk("R5 one copy", n_copy, 1);
        chk("R5 order", order_bad, 0);
        wait_zero(20);
        tick(1);
        chk("R6 zero", zero_pwr, 1);
        chk("R6 image", img_valid, 1);
        chk("R6 cap off", cap_sel, 0);
        chk("R6 save line", save_n_oe, 1);
        host_save_n = 1'b1;
        tick(3);
        chk("R6 line low", save_n_line, 0);
        chk("R10 stays off", zero_pwr, 1);
    endtask

    task automatic t_restore;
        pwr_good = 1'b0;
        tick(3);
        chk("R10 left off", zero_pwr, 0);
        chk("R10 no host", host_owns, 0);
        chk("R10 line free", save_n_oe, 0);
        tick(3);
        chk("R10 wait pwr", host_owns + n_rest, 0);
        pwr_good = 1'b1;
        for (int i = 0; i < 20 && n_rest == 0; i++) tick(1);
        tick(3);
        chk("R8 one restore", n_rest, 1);
        chk("R8 iso held", iso, 1);
        chk("R8 not owned", host_owns, 0);
        rest_done = 1'b1; tick(1); rest_done = 1'b0;
        tick(1);
        chk("R8 handed", host_owns, 1);
        chk("R8 no_data", st_no_data, 0);
        chk("R8 single", n_rest, 1);
    endtask

    task automatic t_powerloss_err;
        int ev0;
        do_arm;
        mv_err = 1'b1;
        ev0 = n_event;
        pwr_good = 1'b0;
        for (int i = 0; i < 20 && n_copy < 2; i++) tick(1);
        chk("R7 copy on loss", n_copy, 2);
        chk("R7 order", order_bad, 0);
        wait_zero(20);
        tick(1);
        chk("R9 error", st_error, 1);
        chk("R9 image", img_valid, 0);
        chk("R9 event", (n_event - ev0) >= 2, 1);
        mv_err = 1'b0;
        tick(3);
        pwr_good = 1'b1;
        wait_host(20);
        tick(1);
        chk("R9 host", host_owns, 1);
        chk("R9 no restore", n_rest, 1);
        chk("R9 no_data", st_no_data, 1);
        chk("R9 sticky", st_error, 1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        t_reset;
        t_nodata_powerup;
        t_unarmed_save;
        t_arm_gates;
        t_save_ok;
        t_restore;
        t_powerloss_err;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule